// File: doc/BRIEF.md
# Goldschmidt Square Root and Reciprocal Square Root Unit

This block takes an unsigned fixed-point mantissa in the range [1, 4) and returns two approximations together: its square root and its reciprocal square root. A small constant table, indexed by the leading bits of the operand, supplies an initial reciprocal-root estimate. Two running values are then refined together. One value tends to the root. The other tends to half the reciprocal root. Each refinement pass is made only of multiply-add operations.

Every multiply-add goes through one shared pipelined multiply-add unit. Each pass first forms a correction term from the two running values. Once that term comes back from the pipeline, the two updates, which do not depend on each other, are issued on consecutive cycles. A caller raises a one-cycle start strobe with the operand. After a fixed number of cycles a one-cycle done strobe appears, and both results are valid on the outputs. Exponent handling, final rounding and special operands belong to the surrounding datapath.

Top module: `gs_sqrt_unit`

## Requirements
- R1: `operand_i` and `sqrt_o` are unsigned with 2 integer bits and FRAC_W fraction bits. For every operand in [1, 4), `sqrt_o` at the done strobe is within 8 LSB of the true square root.
- R2: `rsqrt_o` uses the same format as `sqrt_o`. At the done strobe it is within 8 LSB of 1/sqrt(operand). This holds at both ends of the range: at exactly 1.0 and at the largest code below 4.0.
- R3: `done_o` is first high exactly 2 + MAC_LAT + N_ITER*(3 + 2*MAC_LAT) rising edges after the edge that samples `start_i`. With the defaults this is 23 edges.
- R4: `done_o` is high for exactly one cycle per accepted operation. It is only raised when the last update of the reciprocal-side value leaves the pipeline.
- R5: A start strobe that arrives while an operation is in flight has no effect. The running operation finishes at its original time with the results for its own operand, and no extra done strobe follows.
- R6: When no operation is in flight, `sqrt_o` and `rsqrt_o` hold the last results, whatever `operand_i` does.
- R7: After reset, `done_o`, `sqrt_o` and `rsqrt_o` are zero.
- R8: Each pass issues exactly three multiply-adds. The correction term is issued only when nothing is in flight. The root update is followed on the next cycle by the reciprocal-side update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request, sampled only when idle |
| operand_i | input | FRAC_W+2 | Unsigned mantissa, 2 integer bits, value in [1, 4) |
| done_o | output | 1 | One-cycle strobe: results valid |
| sqrt_o | output | FRAC_W+2 | Square root approximation, 2.FRAC_W format |
| rsqrt_o | output | FRAC_W+2 | Reciprocal square root approximation, 2.FRAC_W format |

## Verification
Several faults show up at the outputs only as a value error when done fires. These include a misrouted pipeline result, a stale correction term, or a table entry read from the wrong bin. The dense operand sweep catches these: an error of one whole pass leaves only about 12 good bits, which is far outside the 8 LSB tolerance. A scheduling fault changes the cycle on which the done strobe rises. Examples are a lost retire, an extra pass, or a correction term issued before the reciprocal-side value has returned. The bench checks that cycle on every operation, and the checker reports an early issue on the same cycle it happens.

// File: rtl/gs_pkg.sv
package gs_pkg;

    // Destination register of a multiply-add issued to the shared pipeline
    typedef enum logic [1:0] {
        DST_X = 2'd0,
        DST_H = 2'd1,
        DST_R = 2'd2
    } dst_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISS_X  = 3'd1,
        ST_ISS_H  = 3'd2,
        ST_WAIT_H = 3'd3,
        ST_ISS_R  = 3'd4,
        ST_WAIT_R = 3'd5
    } st_e;

endpackage

// File: rtl/gs_seed_rom.sv
module gs_seed_rom #(
    parameter int FRAC_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [FRAC_W:0]   seed_o
);
    localparam int DEPTH  = 1 << IDX_W;
    localparam int SEED_W = FRAC_W + 1;

    // Bin i covers [i, i+1) * 4/DEPTH. Its midpoint is (2i+1) * 2^(1-IDX_W).
    // Entry = floor(2^FRAC_W / sqrt(mid)) = isqrt(2^(2*FRAC_W+IDX_W-1) / (2i+1)).
    function automatic logic [SEED_W-1:0] seed_val(input int bin);
        longint unsigned num;
        longint unsigned res;
        longint unsigned trial;
        longint unsigned lim;
        num = (64'd1 << (2 * FRAC_W + IDX_W - 1)) / longint'(2 * bin + 1);
        res = 0;
        for (int k = 31; k >= 0; k--) begin
            trial = res | (64'd1 << k);
            if (trial * trial <= num) res = trial;
        end
        lim = (64'd1 << SEED_W) - 1;
        if (res > lim) res = lim;
        return res[SEED_W-1:0];
    endfunction

    logic [SEED_W-1:0] tbl [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
        assign tbl[gi] = seed_val(gi);
    end

    assign seed_o = tbl[idx_i];

endmodule

// File: rtl/gs_mac_pipe.sv
module gs_mac_pipe
    import gs_pkg::*;
#(
    parameter int W      = 19,
    parameter int FRAC_W = 16,
    parameter int LAT    = 3
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                in_valid_i,
    input  dst_e                in_tag_i,
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    input  logic signed [W-1:0] acc_i,
    output logic                out_valid_o,
    output dst_e                out_tag_o,
    output logic signed [W-1:0] out_res_o
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] sum_w;
    logic signed [W-1:0]  res_d;

    // acc + a*b, with the product realigned to FRAC_W fraction bits
    always_comb begin
        sum_w = ($signed({{W{acc_i[W-1]}}, acc_i}) <<< FRAC_W) + (a_i * b_i);
        res_d = W'(sum_w >>> FRAC_W);
    end

    logic                vld_q [LAT];
    dst_e                tag_q [LAT];
    logic signed [W-1:0] res_q [LAT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < LAT; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= DST_X;
                res_q[i] <= '0;
            end
        end else begin
            vld_q[0] <= in_valid_i;
            tag_q[0] <= in_tag_i;
            res_q[0] <= res_d;
            for (int i = 1; i < LAT; i++) begin
                vld_q[i] <= vld_q[i-1];
                tag_q[i] <= tag_q[i-1];
                res_q[i] <= res_q[i-1];
            end
        end
    end

    assign out_valid_o = vld_q[LAT-1];
    assign out_tag_o   = tag_q[LAT-1];
    assign out_res_o   = res_q[LAT-1];

endmodule

// File: rtl/gs_sqrt_unit.sv
module gs_sqrt_unit
    import gs_pkg::*;
#(
    parameter int FRAC_W  = 16,
    parameter int IDX_W   = 6,
    parameter int MAC_LAT = 3,
    parameter int N_ITER  = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [FRAC_W+1:0]   operand_i,
    output logic                done_o,
    output logic [FRAC_W+1:0]   sqrt_o,
    output logic [FRAC_W+1:0]   rsqrt_o
);
    localparam int W     = FRAC_W + 3;           // sign + 2 integer bits
    localparam int OP_W  = FRAC_W + 2;
    localparam int CNT_W = $clog2(N_ITER + 2);
    localparam logic signed [W-1:0] HALF = W'(1) <<< (FRAC_W - 1);

    typedef struct packed {
        st_e                 st;
        logic                init;
        logic [CNT_W-1:0]    cnt;
        logic signed [W-1:0] n;
        logic signed [W-1:0] y;
        logic signed [W-1:0] x;
        logic signed [W-1:0] h;
        logic signed [W-1:0] r;
        logic                done;
    } state_t;

    state_t st_d, st_q;

    logic [FRAC_W:0]     seed_rd;
    logic                iss_valid;
    dst_e                iss_tag;
    logic signed [W-1:0] iss_a, iss_b, iss_acc;
    logic                ret_valid;
    dst_e                ret_tag;
    logic signed [W-1:0] ret_res;
    logic                busy;

    gs_seed_rom #(
        .FRAC_W (FRAC_W),
        .IDX_W  (IDX_W)
    ) u_rom (
        .idx_i  (operand_i[OP_W-1 -: IDX_W]),
        .seed_o (seed_rd)
    );

    gs_mac_pipe #(
        .W      (W),
        .FRAC_W (FRAC_W),
        .LAT    (MAC_LAT)
    ) u_mac (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .in_valid_i  (iss_valid),
        .in_tag_i    (iss_tag),
        .a_i         (iss_a),
        .b_i         (iss_b),
        .acc_i       (iss_acc),
        .out_valid_o (ret_valid),
        .out_tag_o   (ret_tag),
        .out_res_o   (ret_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        iss_valid = 1'b0;
        iss_tag   = DST_X;
        iss_a     = '0;
        iss_b     = '0;
        iss_acc   = '0;

        // write back whatever leaves the pipeline
        if (ret_valid) begin
            case (ret_tag)
                DST_X:   st_d.x = ret_res;
                DST_H:   st_d.h = ret_res;
                default: st_d.r = ret_res;
            endcase
        end

        case (st_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.n    = $signed({1'b0, operand_i});
                    st_d.y    = $signed({2'b00, seed_rd});
                    st_d.init = 1'b1;
                    st_d.cnt  = '0;
                    st_d.st   = ST_ISS_X;
                end
            end
            ST_ISS_X: begin
                iss_valid = 1'b1;
                iss_tag   = DST_X;
                if (st_q.init) begin
                    iss_a   = st_q.y;     // x = Y * n
                    iss_b   = st_q.n;
                    iss_acc = '0;
                end else begin
                    iss_a   = st_q.x;     // x' = x + x * r
                    iss_b   = st_q.r;
                    iss_acc = st_q.x;
                end
                st_d.st = ST_ISS_H;
            end
            ST_ISS_H: begin
                iss_valid = 1'b1;
                iss_tag   = DST_H;
                if (st_q.init) begin
                    iss_a   = st_q.y;     // h = Y * 0.5
                    iss_b   = HALF;
                    iss_acc = '0;
                end else begin
                    iss_a   = st_q.h;     // h' = h + h * r
                    iss_b   = st_q.r;
                    iss_acc = st_q.h;
                end
                st_d.st = ST_WAIT_H;
            end
            ST_WAIT_H: begin
                if (ret_valid && ret_tag == DST_H) begin
                    if (st_q.cnt == CNT_W'(N_ITER)) begin
                        st_d.done = 1'b1;
                        st_d.st   = ST_IDLE;
                    end else begin
                        st_d.st = ST_ISS_R;
                    end
                end
            end
            ST_ISS_R: begin
                iss_valid = 1'b1;
                iss_tag   = DST_R;
                iss_a     = st_q.x;       // r = 0.5 - x * h
                iss_b     = -st_q.h;
                iss_acc   = HALF;
                st_d.init = 1'b0;
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.st   = ST_WAIT_R;
            end
            ST_WAIT_R: begin
                if (ret_valid && ret_tag == DST_R) st_d.st = ST_ISS_X;
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{st: ST_IDLE, init: 1'b0, cnt: '0, n: '0, y: '0,
                      x: '0, h: '0, r: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.st != ST_IDLE);
    assign done_o = st_q.done;

    // saturate onto the unsigned output format
    assign sqrt_o  = st_q.x[W-1] ? '0 : st_q.x[OP_W-1:0];
    assign rsqrt_o = st_q.h[W-1] ? '0 :
                     (st_q.h[FRAC_W+1] ? '1 : {st_q.h[FRAC_W:0], 1'b0});

endmodule

// File: rtl/gs_sqrt_chk.sv
module gs_sqrt_chk
    import gs_pkg::*;
#(
    parameter int OP_W = 18
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic            done_o,
    input logic [OP_W-1:0] sqrt_o,
    input logic [OP_W-1:0] rsqrt_o,
    input logic            busy,
    input logic            iss_valid,
    input dst_e            iss_tag,
    input logic            ret_valid,
    input dst_e            ret_tag
);
    logic [2:0] infl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) infl_q <= '0;
        else infl_q <= infl_q + {2'b00, iss_valid} - {2'b00, ret_valid};
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R4
    done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(ret_valid && ret_tag == DST_H));

    // R8
    pair_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_valid && iss_tag == DST_X) |=> (iss_valid && iss_tag == DST_H));

    // R8
    r_after_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iss_valid && iss_tag == DST_R) |-> (infl_q == 3'd0));

    // R8
    inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        infl_q <= 3'd2);

    // R5
    start_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> $past(start_i));

    // R5
    retire_in_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_valid |-> busy);

    // R6
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && !done_o) |-> ($stable(sqrt_o) && $stable(rsqrt_o)));

endmodule

bind gs_sqrt_unit gs_sqrt_chk #(.OP_W(FRAC_W + 2)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .done_o    (done_o),
    .sqrt_o    (sqrt_o),
    .rsqrt_o   (rsqrt_o),
    .busy      (busy),
    .iss_valid (iss_valid),
    .iss_tag   (iss_tag),
    .ret_valid (ret_valid),
    .ret_tag   (ret_tag)
);

// File: tb/gs_sqrt_unit_tb.sv
`timescale 1ns/1ps
module gs_sqrt_unit_tb;
    localparam int FRAC_W  = 16;
    localparam int OP_W    = FRAC_W + 2;
    localparam int MAC_LAT = 3;
    localparam int N_ITER  = 2;
    localparam int EXP_LAT = 2 + MAC_LAT + N_ITER * (3 + 2 * MAC_LAT);
    localparam real SCALE  = 65536.0;
    localparam real TOL    = 8.0 / 65536.0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [OP_W-1:0] operand = '0;
    logic            done;
    logic [OP_W-1:0] sq, rsq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gs_sqrt_unit #(
        .FRAC_W  (FRAC_W),
        .IDX_W   (6),
        .MAC_LAT (MAC_LAT),
        .N_ITER  (N_ITER)
    ) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .operand_i (operand),
        .done_o    (done),
        .sqrt_o    (sq),
        .rsqrt_o   (rsq)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_real(input string req, input real act, input real exp);
        real diff;
        checks++;
        diff = act - exp;
        if (diff < 0.0) diff = -diff;
        if (diff > TOL) begin
            errors++;
            $display("FAIL %s: actual %f expected %f", req, act, exp);
        end
    endtask

    // one operation; optionally a stray start at cycle stray_at (0 = none)
    task automatic run_op(input logic [OP_W-1:0] v, input int stray_at,
                          input logic [OP_W-1:0] stray_v);
        int  cyc;
        real nv;
        @(negedge clk);
        operand = v;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (stray_at != 0 && cyc == stray_at) begin
                operand = stray_v;
                start   = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        nv = real'(v) / SCALE;
        chk_int("R3 latency", cyc, EXP_LAT);
        chk_real("R1 sqrt", real'(sq) / SCALE, $sqrt(nv));
        chk_real("R2 rsqrt", real'(rsq) / SCALE, 1.0 / $sqrt(nv));
        @(posedge clk);
        @(negedge clk);
        chk_int("R4 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [OP_W-1:0] hold_sq, hold_rsq;
        int extra;
        repeat (3) @(negedge clk);
        // R7: reset values
        chk_int("R7 done reset", int'(done), 0);
        chk_int("R7 sqrt reset", int'(sq), 0);
        chk_int("R7 rsqrt reset", int'(rsq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_int("R7 done after reset", int'(done), 0);

        // R2 boundaries: 1.0 and largest code below 4.0
        run_op(OP_W'(32'h10000), 0, '0);
        run_op('1, 0, '0);

        // R1, R2, R3: dense sweep over [1, 4)
        for (int k = 32'h10000; k < 32'h40000; k += 193) begin
            run_op(OP_W'(k), 0, '0);
        end

        // R5: start while busy is ignored
        run_op(OP_W'(32'h24000), 7, OP_W'(32'h38000));
        extra = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) extra++;
        end
        chk_int("R5 no second done", extra, 0);

        // R6: outputs hold while idle even as the operand moves
        hold_sq  = sq;
        hold_rsq = rsq;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            operand = OP_W'(32'h10000 + i * 4099);
        end
        chk_int("R6 sqrt held", int'(sq), int'(hold_sq));
        chk_int("R6 rsqrt held", int'(rsq), int'(hold_rsq));

        summary();
        $finish;
    end

endmodule